// File: doc/BRIEF.md
# Register and Stack Operation Unit

This unit holds the programmer-visible state of a small 8-bit processor: the accumulator A, the index registers X and Y, the stack pointer SP, a data-page register that supplies the upper address byte for data accesses, an instruction-page register, and the status flags carry (C), zero (Z), negative (N), overflow (V) and interrupt enable (I). It executes three instruction groups that the decoder hands it. The register group covers transfers, increments and decrements, and push and pop of A. The page group moves values between A, SP and the page registers. The system group sets and clears flags.

The decoder pulses `exec_i` with a 2-bit group code, a 4-bit sub-code and an 8-bit immediate. Each accepted instruction takes effect at the clock edge that samples it. A pop is the only exception: it reads a 256-byte stack memory that maps to block RAM, and that read adds one cycle. The sequencer loads the instruction-page register through a separate load port. The ALU writes its flag results through a flag load port. All register values and flags are outputs taken straight from flip-flops.

Top module: `regstack_unit`

## Requirements
- R1: On a clock edge with `rst` high, A, X, Y, the data page and the instruction page become 0x00, SP becomes 0xFF, and all five flags become 0.
- R2: With group 0 (register group), sub-code 0x0 copies A to X, 0x1 copies X to A, 0x2 copies A to Y and 0x3 copies Y to A. The destination is updated on the edge that samples `exec_i`.
- R3: With group 0, sub-codes 0x4, 0x5, 0x6 and 0x7 perform X+1, X-1, Y+1 and Y-1, wrapping modulo 256.
- R4: Every instruction that writes A, X or Y sets Z when the written value is 0x00 and copies bit 7 of that value into N. C, V and I are left unchanged.
- R5: Group 0 sub-code 0x8 (push) writes A to stack[SP] and then decrements SP.
- R6: Group 0 sub-code 0x9 (pop) increments SP on the sampling edge. A (with Z and N) receives stack[new SP] one edge later. An `exec_i` presented in the cycle between those two edges is ignored.
- R7: Group 0 sub-code 0xA copies SP to X. Sub-code 0xB copies X to SP and leaves every flag unchanged.
- R8: With group 1 (page group), sub-code 0x0 copies the data page to A, 0x1 copies A to the data page, 0x2 copies the instruction page to A, 0x3 loads SP from the immediate, and 0x4 copies SP to A.
- R9: A cycle with `ipage_ld_i` high loads `ipage_val_i` into the instruction-page register.
- R10: With group 2 (system group), sub-code 0x1 sets I, 0x2 clears I, 0x3 sets C, 0x4 clears C and 0x5 clears V. No other flag changes.
- R11: A cycle with `flag_ld_i` high loads `flag_val_i` into the flags, with bit0=C, bit1=Z, bit2=N and bit3=V, leaving I alone. The load is ignored in any cycle in which an instruction is accepted or a pop completes.
- R12: Group 3, undefined sub-codes in groups 0 to 2 (including group 0 sub-code 0xF and group 2 sub-code 0x0), and cycles with `exec_i` low change no register and no flag.
- R13: SP wraps modulo 256: a push at SP=0x00 leaves SP at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe for one instruction |
| grp_i | input | 2 | Group: 0 register, 1 page, 2 system, 3 none |
| sub_i | input | 4 | Sub-code within the group |
| imm_i | input | 8 | Immediate operand |
| ipage_ld_i | input | 1 | Load the instruction-page register |
| ipage_val_i | input | 8 | Value for the instruction-page register |
| flag_ld_i | input | 1 | Load C, Z, N, V from the ALU |
| flag_val_i | input | 4 | Flag values {V,N,Z,C} |
| a_o | output | 8 | Accumulator |
| x_o | output | 8 | X register |
| y_o | output | 8 | Y register |
| sp_o | output | 8 | Stack pointer |
| dpage_o | output | 8 | Data-page register |
| ipage_o | output | 8 | Instruction-page register |
| flg_c_o | output | 1 | Carry flag |
| flg_z_o | output | 1 | Zero flag |
| flg_n_o | output | 1 | Negative flag |
| flg_v_o | output | 1 | Overflow flag |
| flg_i_o | output | 1 | Interrupt enable flag |

## Verification
Every result except the pop data appears after the single clock edge that samples the strobe. The bench drives inputs on the falling edge and reads the outputs at the next falling edge. A pop is checked in two steps. At the first falling edge the new SP is present and A still holds its old value. A copy instruction driven in that cycle must then be ignored. At the second falling edge A carries the popped byte and X is checked to be unchanged. The flag load is checked twice: once on its own, where it takes effect after one edge, and once together with an accepted no-op, where it must leave the flags unchanged.

// File: rtl/regstack_pkg.sv
`timescale 1ns/1ps
package regstack_pkg;
  localparam logic [1:0] GRP_REG  = 2'd0;
  localparam logic [1:0] GRP_PAGE = 2'd1;
  localparam logic [1:0] GRP_SYS  = 2'd2;

  typedef enum logic [4:0] {
    OP_NONE, OP_TAX, OP_TXA, OP_TAY, OP_TYA,
    OP_INX, OP_DEX, OP_INY, OP_DEY,
    OP_PUSH, OP_POP, OP_TSX, OP_TXS,
    OP_RD_DP, OP_WR_DP, OP_RD_IP, OP_LD_SP, OP_RD_SP,
    OP_SEI, OP_CLI, OP_SEC, OP_CLC, OP_CLV
  } rs_op_e;
endpackage

// File: rtl/regstack_decode.sv
`timescale 1ns/1ps
module regstack_decode
  import regstack_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] grp_i,
  input  logic [3:0] sub_i,
  output rs_op_e     op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (en_i) begin
      unique case (grp_i)
        GRP_REG: begin
          case (sub_i)
            4'h0: op_o = OP_TAX;
            4'h1: op_o = OP_TXA;
            4'h2: op_o = OP_TAY;
            4'h3: op_o = OP_TYA;
            4'h4: op_o = OP_INX;
            4'h5: op_o = OP_DEX;
            4'h6: op_o = OP_INY;
            4'h7: op_o = OP_DEY;
            4'h8: op_o = OP_PUSH;
            4'h9: op_o = OP_POP;
            4'hA: op_o = OP_TSX;
            4'hB: op_o = OP_TXS;
            default: op_o = OP_NONE;
          endcase
        end
        GRP_PAGE: begin
          case (sub_i)
            4'h0: op_o = OP_RD_DP;
            4'h1: op_o = OP_WR_DP;
            4'h2: op_o = OP_RD_IP;
            4'h3: op_o = OP_LD_SP;
            4'h4: op_o = OP_RD_SP;
            default: op_o = OP_NONE;
          endcase
        end
        GRP_SYS: begin
          case (sub_i)
            4'h1: op_o = OP_SEI;
            4'h2: op_o = OP_CLI;
            4'h3: op_o = OP_SEC;
            4'h4: op_o = OP_CLC;
            4'h5: op_o = OP_CLV;
            default: op_o = OP_NONE;
          endcase
        end
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/regstack_ram.sv
`timescale 1ns/1ps
module regstack_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/regstack_flags.sv
`timescale 1ns/1ps
module regstack_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zn_we_i,
  input  logic [DW-1:0] zn_val_i,
  input  logic          c_set_i,
  input  logic          c_clr_i,
  input  logic          i_set_i,
  input  logic          i_clr_i,
  input  logic          v_clr_i,
  input  logic          ld_i,
  input  logic [3:0]    ld_val_i,
  output logic          c_o,
  output logic          z_o,
  output logic          n_o,
  output logic          v_o,
  output logic          i_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_o <= 1'b0; z_o <= 1'b0; n_o <= 1'b0; v_o <= 1'b0; i_o <= 1'b0;
    end else if (ld_i) begin
      {v_o, n_o, z_o, c_o} <= ld_val_i;
    end else begin
      if (zn_we_i) begin
        z_o <= (zn_val_i == '0);
        n_o <= zn_val_i[DW-1];
      end
      if (c_set_i) c_o <= 1'b1;
      if (c_clr_i) c_o <= 1'b0;
      if (i_set_i) i_o <= 1'b1;
      if (i_clr_i) i_o <= 1'b0;
      if (v_clr_i) v_o <= 1'b0;
    end
  end

  // R4: a register write refreshes Z and N and leaves C untouched
  a_r4_zn_update: assert property (@(posedge clk) disable iff (rst)
    (zn_we_i && !ld_i) |=> (z_o == ($past(zn_val_i) == '0)) && (n_o == $past(zn_val_i[DW-1])) && $stable(c_o));
  // R10: carry set and clear
  a_r10_sec: assert property (@(posedge clk) disable iff (rst) (c_set_i && !ld_i) |=> c_o);
  a_r10_clc: assert property (@(posedge clk) disable iff (rst) (c_clr_i && !ld_i) |=> !c_o);
  a_r10_clv: assert property (@(posedge clk) disable iff (rst) (v_clr_i && !ld_i) |=> !v_o && $stable(c_o));
endmodule

// File: rtl/regstack_unit.sv
`timescale 1ns/1ps
module regstack_unit
  import regstack_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_i,
  input  logic [1:0]    grp_i,
  input  logic [3:0]    sub_i,
  input  logic [DW-1:0] imm_i,
  input  logic          ipage_ld_i,
  input  logic [DW-1:0] ipage_val_i,
  input  logic          flag_ld_i,
  input  logic [3:0]    flag_val_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] dpage_o,
  output logic [DW-1:0] ipage_o,
  output logic          flg_c_o,
  output logic          flg_z_o,
  output logic          flg_n_o,
  output logic          flg_v_o,
  output logic          flg_i_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  rs_op_e        op;
  logic          pop_pend;
  logic          accept;
  logic [DW-1:0] pop_data;
  logic          zn_we;
  logic [DW-1:0] zn_val;

  assign accept = exec_i && !pop_pend;

  regstack_decode u_dec (
    .en_i (accept),
    .grp_i(grp_i),
    .sub_i(sub_i),
    .op_o (op)
  );

  regstack_ram #(.AW(DW), .DW(DW)) u_stack (
    .clk    (clk),
    .we_i   (op == OP_PUSH),
    .waddr_i(sp_o),
    .wdata_i(a_o),
    .re_i   (op == OP_POP),
    .raddr_i(sp_o + ONE),
    .rdata_o(pop_data)
  );

  always_comb begin
    zn_we  = 1'b1;
    zn_val = '0;
    unique case (op)
      OP_TAX, OP_TAY: zn_val = a_o;
      OP_TXA:         zn_val = x_o;
      OP_TYA:         zn_val = y_o;
      OP_INX:         zn_val = x_o + ONE;
      OP_DEX:         zn_val = x_o - ONE;
      OP_INY:         zn_val = y_o + ONE;
      OP_DEY:         zn_val = y_o - ONE;
      OP_TSX, OP_RD_SP: zn_val = sp_o;
      OP_RD_DP:       zn_val = dpage_o;
      OP_RD_IP:       zn_val = ipage_o;
      default:        zn_we  = 1'b0;
    endcase
    if (pop_pend) begin
      zn_we  = 1'b1;
      zn_val = pop_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o      <= '0;
      x_o      <= '0;
      y_o      <= '0;
      sp_o     <= '1;
      dpage_o  <= '0;
      ipage_o  <= '0;
      pop_pend <= 1'b0;
    end else begin
      pop_pend <= (op == OP_POP);
      if (ipage_ld_i) ipage_o <= ipage_val_i;
      unique case (op)
        OP_TXA, OP_TYA, OP_RD_DP, OP_RD_IP, OP_RD_SP: a_o <= zn_val;
        OP_TAX, OP_INX, OP_DEX, OP_TSX:               x_o <= zn_val;
        OP_TAY, OP_INY, OP_DEY:                       y_o <= zn_val;
        OP_PUSH: sp_o    <= sp_o - ONE;
        OP_POP:  sp_o    <= sp_o + ONE;
        OP_TXS:  sp_o    <= x_o;
        OP_LD_SP: sp_o   <= imm_i;
        OP_WR_DP: dpage_o <= a_o;
        default: ;
      endcase
      if (pop_pend) a_o <= pop_data;
    end
  end

  regstack_flags #(.DW(DW)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .zn_we_i (zn_we),
    .zn_val_i(zn_val),
    .c_set_i (op == OP_SEC),
    .c_clr_i (op == OP_CLC),
    .i_set_i (op == OP_SEI),
    .i_clr_i (op == OP_CLI),
    .v_clr_i (op == OP_CLV),
    .ld_i    (flag_ld_i && !exec_i && !pop_pend),
    .ld_val_i(flag_val_i),
    .c_o     (flg_c_o),
    .z_o     (flg_z_o),
    .n_o     (flg_n_o),
    .v_o     (flg_v_o),
    .i_o     (flg_i_o)
  );

  // R5 / R13: push moves SP down by one, wrapping
  a_r5_push_dec: assert property (@(posedge clk) disable iff (rst)
    (accept && grp_i == GRP_REG && sub_i == 4'h8) |=> sp_o == $past(sp_o) - ONE);
  // R6: pop moves SP up by one
  a_r6_pop_inc: assert property (@(posedge clk) disable iff (rst)
    (accept && grp_i == GRP_REG && sub_i == 4'h9) |=> sp_o == $past(sp_o) + ONE);
  // R6: strobe during the pop gap has no effect on X, Y, SP or data page
  a_r6_gap_ignored: assert property (@(posedge clk) disable iff (rst)
    (pop_pend && exec_i) |=> $stable(x_o) && $stable(y_o) && $stable(sp_o) && $stable(dpage_o));
  // R7: SP load from X leaves the flags alone
  a_r7_txs_flags: assert property (@(posedge clk) disable iff (rst)
    (accept && grp_i == GRP_REG && sub_i == 4'hB && !flag_ld_i) |=>
      $stable(flg_z_o) && $stable(flg_n_o) && $stable(flg_c_o) && sp_o == $past(x_o));
  // R12: idle cycle changes nothing
  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    (!exec_i && !pop_pend && !flag_ld_i && !ipage_ld_i) |=>
      $stable(a_o) && $stable(x_o) && $stable(y_o) && $stable(sp_o) && $stable(dpage_o)
      && $stable(ipage_o) && $stable(flg_z_o) && $stable(flg_n_o) && $stable(flg_c_o));
endmodule

// File: tb/regstack_unit_tb.sv
`timescale 1ns/1ps
module regstack_unit_tb;
  localparam logic [1:0] G_REG = 2'd0, G_PAGE = 2'd1, G_SYS = 2'd2, G_NONE = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [1:0] grp_i = '0;
  logic [3:0] sub_i = '0;
  logic [7:0] imm_i = '0;
  logic       ipage_ld_i = 1'b0;
  logic [7:0] ipage_val_i = '0;
  logic       flag_ld_i = 1'b0;
  logic [3:0] flag_val_i = '0;
  logic [7:0] a_o, x_o, y_o, sp_o, dpage_o, ipage_o;
  logic       flg_c_o, flg_z_o, flg_n_o, flg_v_o, flg_i_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regstack_unit u_dut (
    .clk(clk), .rst(rst), .exec_i(exec_i), .grp_i(grp_i), .sub_i(sub_i), .imm_i(imm_i),
    .ipage_ld_i(ipage_ld_i), .ipage_val_i(ipage_val_i),
    .flag_ld_i(flag_ld_i), .flag_val_i(flag_val_i),
    .a_o(a_o), .x_o(x_o), .y_o(y_o), .sp_o(sp_o), .dpage_o(dpage_o), .ipage_o(ipage_o),
    .flg_c_o(flg_c_o), .flg_z_o(flg_z_o), .flg_n_o(flg_n_o), .flg_v_o(flg_v_o), .flg_i_o(flg_i_o)
  );

  // flags packed as {I,V,N,Z,C}
  function automatic logic [7:0] flags();
    return {3'b000, flg_i_o, flg_v_o, flg_n_o, flg_z_o, flg_c_o};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive at falling edge, outputs valid at the next falling edge
  task automatic issue(input logic [1:0] g, input logic [3:0] s, input logic [7:0] i);
    @(negedge clk);
    exec_i = 1'b1; grp_i = g; sub_i = s; imm_i = i;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  task automatic set_a(input logic [7:0] v);
    issue(G_PAGE, 4'h3, v);
    issue(G_PAGE, 4'h4, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 A", a_o, 8'h00); chk("R1 X", x_o, 8'h00); chk("R1 Y", y_o, 8'h00);
    chk("R1 SP", sp_o, 8'hFF); chk("R1 DP", dpage_o, 8'h00); chk("R1 IP", ipage_o, 8'h00);
    chk("R1 flags", flags(), 8'h00);
  endtask

  task automatic t_transfer();
    set_a(8'h80);
    chk("R8 SP->A", a_o, 8'h80); chk("R4 N on A", flags(), 8'h04);
    issue(G_REG, 4'h0, 8'h00); chk("R2 TAX", x_o, 8'h80);
    set_a(8'h00); chk("R4 Z on A", flags(), 8'h02);
    issue(G_REG, 4'h1, 8'h00); chk("R2 TXA", a_o, 8'h80); chk("R4 TXA flags", flags(), 8'h04);
    issue(G_REG, 4'h2, 8'h00); chk("R2 TAY", y_o, 8'h80);
    set_a(8'h05); chk("R4 clear", flags(), 8'h00);
    issue(G_REG, 4'h3, 8'h00); chk("R2 TYA", a_o, 8'h80);
  endtask

  task automatic t_incdec();
    issue(G_REG, 4'h5, 8'h00); chk("R3 DEX", x_o, 8'h7F); chk("R4 DEX flags", flags(), 8'h00);
    issue(G_REG, 4'h4, 8'h00); chk("R3 INX", x_o, 8'h80); chk("R4 INX flags", flags(), 8'h04);
    set_a(8'h00);
    issue(G_REG, 4'h2, 8'h00); chk("R2 TAY zero", y_o, 8'h00);
    issue(G_REG, 4'h7, 8'h00); chk("R3 DEY wrap", y_o, 8'hFF); chk("R4 DEY flags", flags(), 8'h04);
    issue(G_REG, 4'h6, 8'h00); chk("R3 INY wrap", y_o, 8'h00); chk("R4 INY flags", flags(), 8'h02);
  endtask

  task automatic pop_check(input logic [7:0] old_a, input logic [7:0] exp_sp,
                           input logic [7:0] exp_a, input logic [7:0] exp_x);
    issue(G_REG, 4'h9, 8'h00);
    chk("R6 pop SP", sp_o, exp_sp);
    chk("R6 A not yet", a_o, old_a);
    exec_i = 1'b1; grp_i = G_REG; sub_i = 4'h0;  // copy A to X, must be ignored
    @(negedge clk);
    exec_i = 1'b0;
    chk("R6 pop data", a_o, exp_a);
    chk("R6 gap ignored", x_o, exp_x);
  endtask

  task automatic t_stack();
    set_a(8'h11);
    issue(G_PAGE, 4'h3, 8'h22);
    issue(G_REG, 4'hA, 8'h00); chk("R7 TSX", x_o, 8'h22); chk("R4 TSX flags", flags(), 8'h00);
    issue(G_PAGE, 4'h3, 8'h01);
    issue(G_REG, 4'h8, 8'h00); chk("R5 push SP", sp_o, 8'h00);
    issue(G_REG, 4'h1, 8'h00);
    issue(G_REG, 4'h8, 8'h00); chk("R13 push wrap", sp_o, 8'hFF);
    chk("R5 A kept", a_o, 8'h22);
    issue(G_REG, 4'h3, 8'h00); chk("R2 TYA zero", a_o, 8'h00);
    pop_check(8'h00, 8'h00, 8'h22, 8'h22);
    chk("R4 pop flags", flags(), 8'h00);
    pop_check(8'h22, 8'h01, 8'h11, 8'h22);
    set_a(8'h00);
    issue(G_REG, 4'hB, 8'h00); chk("R7 TXS", sp_o, 8'h22); chk("R7 TXS flags", flags(), 8'h02);
  endtask

  task automatic t_page();
    set_a(8'h3C);
    issue(G_PAGE, 4'h1, 8'h00); chk("R8 A->DP", dpage_o, 8'h3C);
    set_a(8'h00);
    issue(G_PAGE, 4'h0, 8'h00); chk("R8 DP->A", a_o, 8'h3C); chk("R8 DP flags", flags(), 8'h00);
    @(negedge clk);
    ipage_ld_i = 1'b1; ipage_val_i = 8'hA5;
    @(negedge clk);
    ipage_ld_i = 1'b0;
    chk("R9 IP load", ipage_o, 8'hA5);
    issue(G_PAGE, 4'h2, 8'h00); chk("R8 IP->A", a_o, 8'hA5); chk("R8 IP flags", flags(), 8'h04);
  endtask

  task automatic t_sys();
    issue(G_SYS, 4'h3, 8'h00); chk("R10 SEC", flags(), 8'h05);
    issue(G_SYS, 4'h4, 8'h00); chk("R10 CLC", flags(), 8'h04);
    issue(G_SYS, 4'h1, 8'h00); chk("R10 SEI", flags(), 8'h14);
    issue(G_SYS, 4'h2, 8'h00); chk("R10 CLI", flags(), 8'h04);
    @(negedge clk);
    flag_ld_i = 1'b1; flag_val_i = 4'hF;
    @(negedge clk);
    flag_ld_i = 1'b0;
    chk("R11 flag load", flags(), 8'h0F);
    issue(G_SYS, 4'h5, 8'h00); chk("R10 CLV", flags(), 8'h07);
    @(negedge clk);
    flag_ld_i = 1'b1; flag_val_i = 4'h0;
    exec_i = 1'b1; grp_i = G_REG; sub_i = 4'hF;
    @(negedge clk);
    flag_ld_i = 1'b0; exec_i = 1'b0;
    chk("R11 load ignored", flags(), 8'h07);
  endtask

  task automatic t_noop();
    logic [7:0] sa, sx, sy, ssp, sdp, sip, sf;
    sa = a_o; sx = x_o; sy = y_o; ssp = sp_o; sdp = dpage_o; sip = ipage_o; sf = flags();
    issue(G_NONE, 4'h0, 8'h55);
    issue(G_NONE, 4'h9, 8'h55);
    issue(G_REG, 4'hC, 8'h55);
    issue(G_REG, 4'hF, 8'h55);
    issue(G_PAGE, 4'h7, 8'h55);
    issue(G_SYS, 4'h0, 8'h55);
    issue(G_SYS, 4'h6, 8'h55);
    repeat (3) @(negedge clk);
    chk("R12 A", a_o, sa); chk("R12 X", x_o, sx); chk("R12 Y", y_o, sy);
    chk("R12 SP", sp_o, ssp); chk("R12 DP", dpage_o, sdp); chk("R12 IP", ipage_o, sip);
    chk("R12 flags", flags(), sf);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_transfer();
    t_incdec();
    t_stack();
    t_page();
    t_sys();
    t_noop();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule